// File: doc/BRIEF.md
# Serial Memory Command Front End

This block is the slave side of an SPI link in front of a byte-wide non-volatile memory. The controller drives chip select, serial clock and data in, and may pause the transfer with a hold input. The serial clock may idle low or high, which covers SPI modes 0 and 3. All serial inputs are oversampled in the system clock domain. The system clock must run at least eight times faster than the serial clock. The block shifts in an 8-bit command and decodes it. It then does one of three things: it streams array bytes out through a synchronous read port, it repeats the live status byte, or it passes decoded requests to the status and write-cycle blocks next to it. Those requests are write-enable set and clear, captured write bytes with their addresses, and commit strobes.

For an array read, a 16-bit address follows the command. The block fetches the first byte in advance so that its most significant bit is ready on the first falling clock edge of the data phase. After each byte it increments the address and fetches the next byte, wrapping at the top of the array. Array storage, protection policy and the write timer belong to the neighbouring blocks.

Top module: `serial_mem_cmd_if`

## Requirements
- R1: Input bits are taken on rising serial clock edges and output bits change after falling edges, most significant bit first, both with the clock idling low (mode 0) and idling high (mode 3).
- R2: Command 0x06 pulses `reqSetWel` once and command 0x04 pulses `reqClrWel` once. After either one, all further clocks are ignored until chip select goes high: there are no more requests and `sdoEn` stays 0.
- R3: A command byte other than 0x06, 0x04, 0x05, 0x01, 0x03 or 0x02 makes the block ignore the bus: no requests and no output enable until chip select goes high and then low again.
- R4: A read command 0x03 takes a 16-bit address, sent high byte first. Address bits at or above `ADDR_W` are ignored, so with the default of 15 address bits, address 0xC001 reads location 0x4001.
- R5: During a read, each data byte comes from the next higher address. After address 2^ADDR_W-1 the read continues at 0x0000, for as long as the clock runs.
- R6: Command 0x05 drives the current `statusByte` out, and repeats it for every further byte clocked while selected.
- R7: A hold starts when `holdN` is low while the serial clock is low, and ends when `holdN` returns high. During a hold `sdoEn` is 0 and clock and data edges are ignored, so a transfer resumes with no lost or extra bits.
- R8: After reset, a command is accepted only after a high-to-low chip select transition. Deselecting in the middle of a byte aborts the command with no commit.
- R9: A read command received while `writeBusy` is 1 is rejected: no read port access and no output enable until the next selection.
- R10: After command 0x02 and its address, every complete data byte is presented on `wrByte`/`wrAddr` with a one-cycle `wrByteValid` pulse. The address wraps within a page of 2^PAGE_W bytes (default 64, so 0x003F is followed by 0x0000). `commitArray` pulses only if chip select rises on a byte boundary after at least one data byte.
- R11: After command 0x01, the next byte is presented with `wrByteValid`. `commitStatus` pulses only if chip select rises right after that byte, before any further clock edge.
- R12: `sdoEn` is 0 in reset and whenever the block is deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| mosi | input | 1 | Serial data into the block |
| holdN | input | 1 | Pause request, active low |
| sdoData | output | 1 | Serial data out |
| sdoEn | output | 1 | Output driver enable; 0 means high impedance |
| writeBusy | input | 1 | Internal write cycle active |
| statusByte | input | 8 | Current status register value |
| memRdEn | output | 1 | Read port strobe |
| memAddr | output | ADDR_W | Read port address |
| memRdData | input | 8 | Read data, valid the cycle after `memRdEn` |
| reqSetWel | output | 1 | Write-enable set request pulse |
| reqClrWel | output | 1 | Write-enable clear request pulse |
| wrByteValid | output | 1 | Captured write byte pulse |
| wrByte | output | 8 | Captured write byte |
| wrAddr | output | ADDR_W | Array address for the captured byte |
| commitArray | output | 1 | Start an array write cycle |
| commitStatus | output | 1 | Start a status write cycle |

## Verification
Array reads are run from a table of start addresses in both clock idle levels. The table includes plain addresses, addresses with the ignored top bit set, and starts just below the top of the array. These separate correct bit order and mode handling from address masking and wrap. Writes are driven with complete bytes, with bytes cut short, and with extra clocks after a status byte, which tells a correct commit decision from one that ignores the byte boundary. A hold placed in the middle of an output byte, with clock and data toggled during the pause, shows whether any bit was lost or added. Invalid commands, reads during a busy write and a reset taken while selected show whether the block really stays off the bus.

// File: rtl/smc_pkg.sv
package smc_pkg;

  localparam logic [7:0] OP_SET_WE  = 8'h06;
  localparam logic [7:0] OP_CLR_WE  = 8'h04;
  localparam logic [7:0] OP_RD_STAT = 8'h05;
  localparam logic [7:0] OP_WR_STAT = 8'h01;
  localparam logic [7:0] OP_RD_ARR  = 8'h03;
  localparam logic [7:0] OP_WR_ARR  = 8'h02;

  typedef enum logic [3:0] {
    S_IDLE,
    S_OPCODE,
    S_ADDR_HI,
    S_ADDR_LO,
    S_RD_DATA,
    S_STAT_OUT,
    S_WR_STAT,
    S_STAT_DONE,
    S_WR_ARR,
    S_WAIT_DESEL
  } cmdState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic sample;
    logic loadAddrHi;
    logic loadAddrLo;
    logic fetch;
    logic addrInc;
    logic addrIncPage;
    logic loadStat;
    logic present;
    logic shiftOut;
    logic capWr;
  } dpStrobe_t;

endpackage

// File: rtl/smc_sync.sv
module smc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic csN,
  input  logic sck,
  input  logic mosi,
  input  logic holdN,
  output logic csSel,
  output logic csFall,
  output logic csRise,
  output logic sckLvl,
  output logic sckRise,
  output logic sckFall,
  output logic mosiS,
  output logic holdNS
);

  localparam int NSIG = 4;

  logic [NSIG-1:0] rawVec;
  logic [NSIG-1:0] stg [STAGES];
  logic [NSIG-1:0] syncd;
  logic [1:0]      lastQ;

  assign rawVec = {csN, sck, mosi, holdN};

  // reset value 0 so a chip select held low through reset gives no edge
  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stg[g] <= '0;
        else       stg[g] <= rawVec;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stg[g] <= '0;
        else       stg[g] <= stg[g-1];
      end
    end
  end

  assign syncd = stg[STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lastQ <= '0;
    else       lastQ <= syncd[3:2];
  end

  assign csSel   = ~syncd[3];
  assign csFall  = ~syncd[3] &  lastQ[1];
  assign csRise  =  syncd[3] & ~lastQ[1];
  assign sckLvl  =  syncd[2];
  assign sckRise =  syncd[2] & ~lastQ[0];
  assign sckFall = ~syncd[2] &  lastQ[0];
  assign mosiS   =  syncd[1];
  assign holdNS  =  syncd[0];

endmodule

// File: rtl/smc_dpath.sv
module smc_dpath
  import smc_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int PAGE_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              mosiS,
  input  dpStrobe_t         str,
  input  logic [7:0]        memRdData,
  input  logic [7:0]        statusByte,
  output logic              bitLast,
  output logic              byteStart,
  output logic [7:0]        inByte,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memAddr,
  output logic              sdoData,
  output logic [7:0]        wrByte,
  output logic [ADDR_W-1:0] wrAddr
);

  localparam int HI_W = ADDR_W - 8;

  logic              clrN;
  logic [6:0]        shReg;
  logic [2:0]        bitCnt;
  logic [ADDR_W-1:0] addrQ;
  logic              rdPend;
  logic [7:0]        nxtByte;
  logic [7:0]        outReg;
  logic [7:0]        wrByteQ;
  logic [ADDR_W-1:0] wrAddrQ;

  // bit counter and shift register clear as soon as chip select rises
  assign clrN = rstN & ~csN;

  always_ff @(posedge clk or negedge clrN) begin
    if (!clrN) begin
      shReg  <= '0;
      bitCnt <= '0;
    end else if (str.sample) begin
      shReg  <= inByte[6:0];
      bitCnt <= bitCnt + 3'd1;
    end
  end

  assign inByte    = {shReg, mosiS};
  assign bitLast   = (bitCnt == 3'd7);
  assign byteStart = (bitCnt == 3'd0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
    end else if (str.loadAddrHi) begin
      addrQ[ADDR_W-1:8] <= inByte[HI_W-1:0];
    end else if (str.loadAddrLo) begin
      addrQ[7:0] <= inByte;
    end else if (str.addrInc) begin
      addrQ <= addrQ + ADDR_W'(1);
    end else if (str.addrIncPage) begin
      addrQ[PAGE_W-1:0] <= addrQ[PAGE_W-1:0] + PAGE_W'(1);
    end
  end

  // one-byte prefetch buffer fed by the read port or the status input
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPend  <= 1'b0;
      nxtByte <= '0;
    end else begin
      rdPend <= str.fetch;
      if (str.loadStat)  nxtByte <= statusByte;
      else if (rdPend)   nxtByte <= memRdData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             outReg <= '0;
    else if (str.present)  outReg <= nxtByte;
    else if (str.shiftOut) outReg <= {outReg[6:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrByteQ <= '0;
      wrAddrQ <= '0;
    end else if (str.capWr) begin
      wrByteQ <= inByte;
      wrAddrQ <= addrQ;
    end
  end

  assign memRdEn = str.fetch;
  assign memAddr = addrQ;
  assign sdoData = outReg[7];
  assign wrByte  = wrByteQ;
  assign wrAddr  = wrAddrQ;

  // R10: write address wraps inside its page
  p_page_wrap_r10: assert property (@(posedge clk) disable iff (!rstN)
    (str.addrIncPage && addrQ[PAGE_W-1:0] == '1) |=> (addrQ[PAGE_W-1:0] == '0));

  // R1: eight sampled bits close a byte
  p_bit_wrap_r1: assert property (@(posedge clk) disable iff (!rstN)
    (str.sample && bitLast && !csN) |=> (byteStart || csN));

endmodule

// File: rtl/smc_ctrl.sv
module smc_ctrl
  import smc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       csSel,
  input  logic       csFall,
  input  logic       csRise,
  input  logic       sckLvl,
  input  logic       sckRise,
  input  logic       sckFall,
  input  logic       holdNS,
  input  logic       bitLast,
  input  logic       byteStart,
  input  logic [7:0] inByte,
  input  logic       writeBusy,
  output dpStrobe_t  str,
  output logic       sdoEn,
  output logic       reqSetWel,
  output logic       reqClrWel,
  output logic       wrByteValid,
  output logic       commitArray,
  output logic       commitStatus
);

  cmdState_t state;
  logic holdAct;
  logic fetchPend;
  logic rdMode;
  logic arrAligned;
  logic riseQ, fallQ, byteDone, outState, presentEv;
  logic setQ, clrQ, wrValidQ, commitArrQ, commitStatQ;

  assign riseQ     = sckRise & csSel & ~holdAct;
  assign fallQ     = sckFall & csSel & ~holdAct;
  assign byteDone  = riseQ & bitLast;
  assign outState  = (state == S_RD_DATA) || (state == S_STAT_OUT);
  assign presentEv = fallQ & byteStart & outState;

  always_comb begin
    str             = '0;
    str.sample      = riseQ;
    str.loadAddrHi  = byteDone && (state == S_ADDR_HI);
    str.loadAddrLo  = byteDone && (state == S_ADDR_LO);
    str.fetch       = fetchPend;
    str.addrInc     = presentEv && (state == S_RD_DATA);
    str.addrIncPage = byteDone && (state == S_WR_ARR);
    str.loadStat    = (byteDone && (state == S_OPCODE) && (inByte == OP_RD_STAT)) ||
                      (presentEv && (state == S_STAT_OUT));
    str.present     = presentEv;
    str.shiftOut    = fallQ && outState && !byteStart;
    str.capWr       = byteDone && ((state == S_WR_STAT) || (state == S_WR_ARR));
  end

  // hold engages only with the serial clock low
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                holdAct <= 1'b0;
    else if (!csSel || holdNS) holdAct <= 1'b0;
    else if (!sckLvl)         holdAct <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= S_IDLE;
      fetchPend   <= 1'b0;
      rdMode      <= 1'b0;
      arrAligned  <= 1'b0;
      setQ        <= 1'b0;
      clrQ        <= 1'b0;
      wrValidQ    <= 1'b0;
      commitArrQ  <= 1'b0;
      commitStatQ <= 1'b0;
    end else begin
      setQ        <= 1'b0;
      clrQ        <= 1'b0;
      commitArrQ  <= 1'b0;
      commitStatQ <= 1'b0;
      wrValidQ    <= str.capWr;
      fetchPend   <= (str.loadAddrLo && rdMode) || str.addrInc;
      if (!csSel) begin
        commitArrQ  <= csRise && (state == S_WR_ARR) && arrAligned;
        commitStatQ <= csRise && (state == S_STAT_DONE);
        state       <= S_IDLE;
      end else begin
        unique case (state)
          S_IDLE: if (csFall) state <= S_OPCODE;
          S_OPCODE: if (byteDone) begin
            arrAligned <= 1'b0;
            unique case (inByte)
              OP_SET_WE:  begin setQ <= 1'b1; state <= S_WAIT_DESEL; end
              OP_CLR_WE:  begin clrQ <= 1'b1; state <= S_WAIT_DESEL; end
              OP_RD_STAT: state <= S_STAT_OUT;
              OP_WR_STAT: state <= S_WR_STAT;
              OP_RD_ARR: begin
                rdMode <= 1'b1;
                state  <= writeBusy ? S_IDLE : S_ADDR_HI;
              end
              OP_WR_ARR: begin rdMode <= 1'b0; state <= S_ADDR_HI; end
              default:   state <= S_IDLE;
            endcase
          end
          S_ADDR_HI: if (byteDone) state <= S_ADDR_LO;
          S_ADDR_LO: if (byteDone) state <= rdMode ? S_RD_DATA : S_WR_ARR;
          S_WR_STAT: if (byteDone) state <= S_STAT_DONE;
          S_STAT_DONE: if (riseQ) state <= S_WAIT_DESEL;
          S_WR_ARR: begin
            if (byteDone)   arrAligned <= 1'b1;
            else if (riseQ) arrAligned <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  assign sdoEn        = csSel & ~holdAct & outState;
  assign reqSetWel    = setQ;
  assign reqClrWel    = clrQ;
  assign wrByteValid  = wrValidQ;
  assign commitArray  = commitArrQ;
  assign commitStatus = commitStatQ;

  // R2: the wait state lasts until deselect
  p_wait_holds_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_WAIT_DESEL && csSel) |=> (state == S_WAIT_DESEL));

  // R3: only a select edge leaves the idle state
  p_idle_until_select_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && !csFall) |=> (state == S_IDLE));

  // R9: a read during a busy write goes nowhere
  p_busy_read_rejected_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_OPCODE && byteDone && writeBusy && inByte == OP_RD_ARR) |=> (state == S_IDLE));

  // R10: commits only appear while deselected
  p_commit_deselected_r10: assert property (@(posedge clk) disable iff (!rstN)
    (commitArray || commitStatus) |-> !csSel);

  // R2: at most one request kind per cycle
  p_single_request_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({reqSetWel, reqClrWel, commitArray, commitStatus, wrByteValid}));

endmodule

// File: rtl/serial_mem_cmd_if.sv
module serial_mem_cmd_if
  import smc_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int PAGE_W = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sck,
  input  logic              mosi,
  input  logic              holdN,
  output logic              sdoData,
  output logic              sdoEn,
  input  logic              writeBusy,
  input  logic [7:0]        statusByte,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [7:0]        memRdData,
  output logic              reqSetWel,
  output logic              reqClrWel,
  output logic              wrByteValid,
  output logic [7:0]        wrByte,
  output logic [ADDR_W-1:0] wrAddr,
  output logic              commitArray,
  output logic              commitStatus
);

  logic csSel, csFall, csRise, sckLvl, sckRise, sckFall, mosiS, holdNS;
  logic bitLast, byteStart;
  logic [7:0] inByte;
  dpStrobe_t str;

  smc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .mosi(mosi), .holdN(holdN),
    .csSel(csSel), .csFall(csFall), .csRise(csRise), .sckLvl(sckLvl),
    .sckRise(sckRise), .sckFall(sckFall), .mosiS(mosiS), .holdNS(holdNS)
  );

  smc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .csSel(csSel), .csFall(csFall), .csRise(csRise),
    .sckLvl(sckLvl), .sckRise(sckRise), .sckFall(sckFall), .holdNS(holdNS),
    .bitLast(bitLast), .byteStart(byteStart), .inByte(inByte),
    .writeBusy(writeBusy), .str(str), .sdoEn(sdoEn),
    .reqSetWel(reqSetWel), .reqClrWel(reqClrWel), .wrByteValid(wrByteValid),
    .commitArray(commitArray), .commitStatus(commitStatus)
  );

  smc_dpath #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_dpath (
    .clk(clk), .rstN(rstN), .csN(csN), .mosiS(mosiS), .str(str),
    .memRdData(memRdData), .statusByte(statusByte),
    .bitLast(bitLast), .byteStart(byteStart), .inByte(inByte),
    .memRdEn(memRdEn), .memAddr(memAddr), .sdoData(sdoData),
    .wrByte(wrByte), .wrAddr(wrAddr)
  );

endmodule

// File: tb/serial_mem_cmd_if_test.sv
`timescale 1ns/1ps
module serial_mem_cmd_if_test;

  logic clk = 1'b0;
  logic rstN, csN, sck, mosi, holdN, writeBusy;
  logic [7:0] statusByte, memRdData;
  logic sdoData, sdoEn, memRdEn, reqSetWel, reqClrWel, wrByteValid;
  logic commitArray, commitStatus;
  logic [14:0] memAddr, wrAddr;
  logic [7:0] wrByte;

  int nChecks = 0;
  int nErr = 0;
  int setCnt = 0, clrCnt = 0, comACnt = 0, comSCnt = 0, rdCnt = 0, wrCnt = 0;
  int oeSeen = 0;
  logic idleHi = 1'b0;
  logic [7:0]  capByte [8];
  logic [14:0] capAddr [8];

  // addr[31:16], idle level [8], byte count [7:0]
  localparam logic [31:0] RD_VEC [6] = '{
    32'h0000_0003, 32'h1234_0102, 32'h7FFE_0004,
    32'hC001_0102, 32'hFFFF_0002, 32'h2A3F_0103
  };

  always #2.5 clk = ~clk;

  serial_mem_cmd_if uut (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .mosi(mosi), .holdN(holdN),
    .sdoData(sdoData), .sdoEn(sdoEn), .writeBusy(writeBusy), .statusByte(statusByte),
    .memRdEn(memRdEn), .memAddr(memAddr), .memRdData(memRdData),
    .reqSetWel(reqSetWel), .reqClrWel(reqClrWel), .wrByteValid(wrByteValid),
    .wrByte(wrByte), .wrAddr(wrAddr), .commitArray(commitArray), .commitStatus(commitStatus)
  );

  function automatic logic [7:0] memf(input logic [14:0] a);
    return a[7:0] ^ {a[14:8], 1'b1} ^ 8'h3C;
  endfunction

  always @(posedge clk) if (memRdEn) memRdData <= memf(memAddr);

  always @(negedge clk) begin
    if (reqSetWel) setCnt++;
    if (reqClrWel) clrCnt++;
    if (commitArray) comACnt++;
    if (commitStatus) comSCnt++;
    if (memRdEn) rdCnt++;
    if (wrByteValid) begin
      if (wrCnt < 8) begin
        capByte[wrCnt] = wrByte;
        capAddr[wrCnt] = wrAddr;
      end
      wrCnt++;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic sel();
    sck = idleHi; #50; csN = 1'b0; #100;
  endtask

  task automatic desel();
    #50; if (!idleHi) sck = 1'b0; #50; csN = 1'b1; #100;
  endtask

  task automatic xfer(input logic [7:0] tx, input int nbits, input int holdAt,
                      output logic [7:0] rx);
    rx = '0;
    for (int i = 0; i < nbits; i++) begin
      if (i == holdAt) begin
        sck = 1'b0; #50; holdN = 1'b0; #50;
        chk("R7 output off during hold", {31'd0, sdoEn}, 32'd0);
        repeat (2) begin sck = 1'b1; mosi = ~mosi; #50; sck = 1'b0; #50; end
        holdN = 1'b1; #50;
      end
      sck = 1'b0; mosi = tx[7-i]; #50;
      sck = 1'b1; rx[7-i] = sdoData; if (sdoEn) oeSeen++; #50;
    end
  endtask

  initial begin
    #(200000 * 5);
    nErr++; nChecks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    logic [7:0] r;
    int b0;
    rstN = 1'b0; csN = 1'b1; sck = 1'b0; mosi = 1'b0; holdN = 1'b1;
    writeBusy = 1'b0; statusByte = 8'h00;
    #51.3; rstN = 1'b1; #100;
    chk("R12 output off after reset", {31'd0, sdoEn}, 32'd0);

    // table-driven array reads (R1 R4 R5)
    for (int v = 0; v < 6; v++) begin
      logic [15:0] a16;
      a16 = RD_VEC[v][31:16];
      idleHi = RD_VEC[v][8];
      sel();
      xfer(8'h03, 8, -1, r); xfer(a16[15:8], 8, -1, r); xfer(a16[7:0], 8, -1, r);
      oeSeen = 0;
      for (int k = 0; k < int'(RD_VEC[v][7:0]); k++) begin
        xfer(8'h00, 8, -1, r);
        chk("R1 R4 R5 read byte", {24'd0, r}, {24'd0, memf(a16[14:0] + 15'(k))});
      end
      chk("R1 output enabled for data", oeSeen, 32'(RD_VEC[v][7:0] * 8));
      desel();
      chk("R12 output off when deselected", {31'd0, sdoEn}, 32'd0);
    end
    idleHi = 1'b0;

    // R2 set and clear write enable, extra clocks ignored
    b0 = setCnt; sel(); xfer(8'h06, 8, -1, r); desel();
    chk("R2 set request", setCnt - b0, 1);
    b0 = clrCnt; oeSeen = 0; sel(); xfer(8'h04, 8, -1, r); xfer(8'h05, 8, -1, r);
    xfer(8'h04, 8, -1, r); desel();
    chk("R2 clear request once", clrCnt - b0, 1);
    chk("R2 no output after clear", oeSeen, 0);

    // R6 status repeats
    idleHi = 1'b1; statusByte = 8'hA5;
    sel(); xfer(8'h05, 8, -1, r);
    for (int k = 0; k < 3; k++) begin
      xfer(8'h00, 8, -1, r);
      chk("R6 status byte", {24'd0, r}, 32'h0000_00A5);
    end
    desel(); idleHi = 1'b0;

    // R3 invalid command
    b0 = setCnt; oeSeen = 0;
    sel(); xfer(8'hFF, 8, -1, r); xfer(8'h06, 8, -1, r); xfer(8'h05, 8, -1, r); desel();
    chk("R3 no request after invalid", setCnt - b0, 0);
    chk("R3 no output after invalid", oeSeen, 0);
    sel(); xfer(8'h06, 8, -1, r); desel();
    chk("R3 recovery after reselect", setCnt - b0, 1);

    // R7 hold in the middle of an output byte
    sel(); xfer(8'h03, 8, -1, r); xfer(8'h01, 8, -1, r); xfer(8'h00, 8, -1, r);
    xfer(8'h00, 8, 3, r);
    chk("R7 byte across hold", {24'd0, r}, {24'd0, memf(15'h0100)});
    xfer(8'h00, 8, -1, r);
    chk("R7 next byte after hold", {24'd0, r}, {24'd0, memf(15'h0101)});
    desel();

    // R10 array write with page wrap
    b0 = comACnt; wrCnt = 0;
    sel(); xfer(8'h02, 8, -1, r); xfer(8'h00, 8, -1, r); xfer(8'h3E, 8, -1, r);
    xfer(8'h11, 8, -1, r); xfer(8'h22, 8, -1, r); xfer(8'h33, 8, -1, r); desel();
    chk("R10 byte count", wrCnt, 3);
    chk("R10 addr 0", {17'd0, capAddr[0]}, 32'h3E);
    chk("R10 addr 1", {17'd0, capAddr[1]}, 32'h3F);
    chk("R10 page wrap addr", {17'd0, capAddr[2]}, 32'h00);
    chk("R10 data", {8'd0, capByte[0], capByte[1], capByte[2]}, 32'h0011_2233);
    chk("R10 commit on boundary", comACnt - b0, 1);

    // R8 R10 abort in the middle of a byte
    b0 = comACnt;
    sel(); xfer(8'h02, 8, -1, r); xfer(8'h00, 8, -1, r); xfer(8'h10, 8, -1, r);
    xfer(8'h44, 8, -1, r); xfer(8'h55, 3, -1, r); desel();
    chk("R8 R10 no commit off boundary", comACnt - b0, 0);

    // R11 status write
    b0 = comSCnt;
    sel(); xfer(8'h01, 8, -1, r); xfer(8'h9C, 8, -1, r); desel();
    chk("R11 status commit", comSCnt - b0, 1);
    chk("R11 status byte presented", {24'd0, wrByte}, 32'h9C);
    sel(); xfer(8'h01, 8, -1, r); xfer(8'h9C, 8, -1, r); xfer(8'h00, 1, -1, r); desel();
    chk("R11 no commit after extra clock", comSCnt - b0, 1);

    // R9 read while busy
    writeBusy = 1'b1; b0 = rdCnt; oeSeen = 0;
    sel(); xfer(8'h03, 8, -1, r); xfer(8'h00, 8, -1, r); xfer(8'h00, 8, -1, r);
    xfer(8'h00, 8, -1, r); desel();
    writeBusy = 1'b0;
    chk("R9 no read port access", rdCnt - b0, 0);
    chk("R9 no output", oeSeen, 0);

    // R8 reset taken while selected
    b0 = setCnt;
    rstN = 1'b0; csN = 1'b0; sck = 1'b0; #50; rstN = 1'b1; #100;
    xfer(8'h06, 8, -1, r); desel();
    chk("R8 no command without select edge", setCnt - b0, 0);
    sel(); xfer(8'h06, 8, -1, r); desel();
    chk("R8 command after select edge", setCnt - b0, 1);

    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

endmodule